// File: doc/BRIEF.md
# Two-Word Instruction Fetch and Decode Unit

This unit sits at the front of a 16-bit processor. It walks the program counter through a byte-addressed, 16-bit-wide instruction memory and reads one word per request. It splits the first word into source register, destination register, group and type nibbles. From the group and type it decides whether an extended word, holding an immediate value or an address, follows. If one does, it reads that word as well. When the instruction is complete, it hands one registered bundle to the execute stage.

After a hand-off the unit stays idle until the execute stage reports that it is done. At that point the execute stage may also supply a new fetch address, for branches, calls and returns. Encodings that belong to no defined instruction are flagged and replaced by a harmless no-operation bundle, so the execute stage never sees raw garbage fields.

Top module: `ifd_fetch_decode`

## Requirements
- R1: While reset is asserted, `mem_req` and `dec_valid` stay low. The first request after reset is made at address `RESET_PC` (default 0x0000).
- R2: The byte at the even address arrives in `mem_rdata[15:8]` and is the first byte of the instruction. Its high nibble `[15:12]` is the source register code and its low nibble `[11:8]` is the destination register code. In the second byte, `[7:4]` is the type and `[3:0]` is the group. For a legal instruction these four fields appear unchanged on `dec_src`, `dec_dst`, `dec_type` and `dec_group`.
- R3: Some instructions carry a second word, which appears on `dec_operand` with `dec_long`=1. For these the mode is type bits [2:0] and the addressing bits are type bits [1:0]:
  - group 0 with type 2, 3, 4 or 6;
  - every legal type of groups 1 and 2;
  - group 3 with addressing bits 0 or 2;
  - groups 4, 5, 6, 7, 8 and 10 with mode 1, 3, 4, 6 or 7;
  - group 9 with mode 2, 3, 5 or 6.

  All other instructions are one word, with `dec_long`=0 and `dec_operand`=0.
- R4: Every request uses an even address. Each word read advances the fetch address by 2, wrapping modulo 2^16. `dec_pc` is the address of the instruction's first word.
- R5: A request holds `mem_req` high with a stable `mem_addr` until a cycle in which `mem_rvalid` is high. That cycle consumes exactly one word. `mem_rvalid` is ignored while `mem_req` is low.
- R6: `dec_valid` rises in the cycle after the last word of an instruction is accepted and stays high for exactly one cycle. No new request is made until `exec_ready` is seen high.
- R7: An encoding is illegal if it matches any of the following:
  - group 11 to 15;
  - group 0 with type 12 to 15;
  - group 1 or 2 with type 13 to 15;
  - group 3 with addressing bits 3;
  - group 6 with type 8 or above;
  - group 9 with mode 7.

  An illegal encoding gives `dec_illegal`=1 with group 0, type 1 (no-op), register codes 0, byte flag 0, long flag 0 and operand 0. It is always treated as a one-word instruction.
- R8: `dec_byte` is 1 in these cases and 0 otherwise:
  - group 3 when type bit 3 is set;
  - groups 4, 5, 6, 7, 8 and 10 with mode 5 to 7;
  - group 9 with mode 4 to 6.
- R9: When `exec_ready` is high together with `redirect_valid`, the next fetch starts at `redirect_pc` with bit 0 cleared. `redirect_valid` without `exec_ready` has no effect.
- R10: All `dec_*` bundle outputs other than `dec_valid` change only together with a `dec_valid` pulse. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Instruction word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word (always even) |
| mem_rvalid | input | 1 | Read data valid, consumes the pending request |
| mem_rdata | input | 16 | Read data word |
| exec_ready | input | 1 | Execute stage finished, start next fetch |
| redirect_valid | input | 1 | Use `redirect_pc` as next fetch address (with `exec_ready`) |
| redirect_pc | input | ADDR_W | New fetch address |
| dec_valid | output | 1 | One-cycle strobe: bundle is new |
| dec_pc | output | ADDR_W | Address of the instruction |
| dec_src | output | 4 | Source register code |
| dec_dst | output | 4 | Destination register code |
| dec_group | output | 4 | Instruction group |
| dec_type | output | 4 | Type within group |
| dec_byte | output | 1 | Byte-size memory operand |
| dec_long | output | 1 | Instruction had an extension word |
| dec_operand | output | 16 | Extension word, zero for one-word instructions |
| dec_illegal | output | 1 | Encoding undefined, bundle replaced by no-op |

## Verification
The properties assume that the memory answers each request with exactly one `mem_rvalid` cycle and never asserts it twice for one word. They also assume that a redirect is offered only while the execute stage hands back control. The bench memory model drops `mem_rvalid` right after every response, waits a programmable number of cycles before answering, and drives deliberate stray `mem_rvalid` pulses only while no request is open. Redirects are driven together with `exec_ready`, except in one scenario that checks a lone `redirect_valid` changes nothing.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int WORD_W  = 16;
    localparam int NIB_W   = 4;

    localparam logic [NIB_W-1:0] G_MISC   = 4'd0;
    localparam logic [NIB_W-1:0] G_JUMP   = 4'd1;
    localparam logic [NIB_W-1:0] G_CALL   = 4'd2;
    localparam logic [NIB_W-1:0] G_LDST   = 4'd3;
    localparam logic [NIB_W-1:0] G_ADDSUB = 4'd4;
    localparam logic [NIB_W-1:0] G_ANDOR  = 4'd5;
    localparam logic [NIB_W-1:0] G_XOR    = 4'd6;
    localparam logic [NIB_W-1:0] G_SHIFT  = 4'd7;
    localparam logic [NIB_W-1:0] G_MULDIV = 4'd8;
    localparam logic [NIB_W-1:0] G_INCDEC = 4'd9;
    localparam logic [NIB_W-1:0] G_CMPNEG = 4'd10;

    localparam logic [NIB_W-1:0] MISC_LAST_TYPE = 4'd11;
    localparam logic [NIB_W-1:0] BRANCH_LAST_TYPE = 4'd12;
    localparam logic [NIB_W-1:0] NOP_TYPE = 4'd1;

    typedef struct packed {
        logic legal;
        logic is_long;
        logic is_byte;
    } cls_t;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_HEAD = 2'd1,
        ST_TAIL = 2'd2,
        ST_HOLD = 2'd3
    } fsm_e;

endpackage

// File: rtl/ifd_classify.sv
module ifd_classify
    import ifd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cls_t              cls
);

    logic [NIB_W-1:0] grp;
    logic [NIB_W-1:0] typ;
    logic [2:0]       mode;
    logic [1:0]       amode;

    always_comb begin
        grp   = word[NIB_W-1:0];
        typ   = word[2*NIB_W-1:NIB_W];
        mode  = typ[2:0];
        amode = typ[1:0];
        cls   = '0;
        case (grp)
            G_MISC: begin
                cls.legal   = (typ <= MISC_LAST_TYPE);
                cls.is_long = (typ == 4'd2) || (typ == 4'd3) ||
                              (typ == 4'd4) || (typ == 4'd6);
            end
            G_JUMP, G_CALL: begin
                cls.legal   = (typ <= BRANCH_LAST_TYPE);
                cls.is_long = 1'b1;
            end
            G_LDST: begin
                cls.legal   = (amode != 2'd3);
                cls.is_long = (amode != 2'd1);
                cls.is_byte = typ[3];
            end
            G_ADDSUB, G_ANDOR, G_XOR, G_SHIFT, G_MULDIV, G_CMPNEG: begin
                cls.legal   = (grp != G_XOR) || !typ[3];
                cls.is_long = mode inside {3'd1, 3'd3, 3'd4, 3'd6, 3'd7};
                cls.is_byte = (mode >= 3'd5);
            end
            G_INCDEC: begin
                cls.legal   = (mode != 3'd7);
                cls.is_long = mode inside {3'd2, 3'd3, 3'd5, 3'd6};
                cls.is_byte = mode inside {3'd4, 3'd5, 3'd6};
            end
            default: cls = '0;
        endcase
    end

endmodule

// File: rtl/ifd_sequencer.sv
module ifd_sequencer
    import ifd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              exec_ready,
    input  logic              redirect_valid,
    input  logic [ADDR_W-1:0] redirect_pc,
    output logic [WORD_W-1:0] cls_word,
    input  cls_t              cls,
    output logic              dec_valid,
    output logic [ADDR_W-1:0] dec_pc,
    output logic [NIB_W-1:0]  dec_src,
    output logic [NIB_W-1:0]  dec_dst,
    output logic [NIB_W-1:0]  dec_group,
    output logic [NIB_W-1:0]  dec_type,
    output logic              dec_byte,
    output logic              dec_long,
    output logic [WORD_W-1:0] dec_operand,
    output logic              dec_illegal
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    typedef struct packed {
        fsm_e              fsm;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] head;
        logic [ADDR_W-1:0] head_pc;
        logic              valid;
        logic [ADDR_W-1:0] ipc;
        logic [NIB_W-1:0]  src;
        logic [NIB_W-1:0]  dst;
        logic [NIB_W-1:0]  grp;
        logic [NIB_W-1:0]  typ;
        logic              byt;
        logic              lng;
        logic [WORD_W-1:0] opnd;
        logic              ill;
    } seq_t;

    seq_t              s_d, s_q;
    logic              commit;
    logic [WORD_W-1:0] opnd_sel;
    logic [ADDR_W-1:0] ipc_sel;

    assign cls_word = (s_q.fsm == ST_TAIL) ? s_q.head : mem_rdata;

    always_comb begin
        s_d      = s_q;
        s_d.valid = 1'b0;
        commit   = 1'b0;
        opnd_sel = '0;
        ipc_sel  = (s_q.fsm == ST_TAIL) ? s_q.head_pc : s_q.pc;
        case (s_q.fsm)
            ST_BOOT: s_d.fsm = ST_HEAD;
            ST_HEAD: begin
                if (mem_rvalid) begin
                    s_d.head    = mem_rdata;
                    s_d.head_pc = s_q.pc;
                    s_d.pc      = s_q.pc + STEP;
                    if (cls.legal && cls.is_long) s_d.fsm = ST_TAIL;
                    else                          commit  = 1'b1;
                end
            end
            ST_TAIL: begin
                if (mem_rvalid) begin
                    s_d.pc   = s_q.pc + STEP;
                    opnd_sel = mem_rdata;
                    commit   = 1'b1;
                end
            end
            ST_HOLD: begin
                if (exec_ready) begin
                    s_d.fsm = ST_HEAD;
                    if (redirect_valid) s_d.pc = {redirect_pc[ADDR_W-1:1], 1'b0};
                end
            end
            default: s_d.fsm = ST_BOOT;
        endcase
        if (commit) begin
            s_d.fsm   = ST_HOLD;
            s_d.valid = 1'b1;
            s_d.ipc   = ipc_sel;
            s_d.ill   = !cls.legal;
            if (cls.legal) begin
                s_d.src  = cls_word[WORD_W-1:WORD_W-NIB_W];
                s_d.dst  = cls_word[WORD_W-NIB_W-1:WORD_W-2*NIB_W];
                s_d.typ  = cls_word[2*NIB_W-1:NIB_W];
                s_d.grp  = cls_word[NIB_W-1:0];
                s_d.byt  = cls.is_byte;
                s_d.lng  = cls.is_long;
                s_d.opnd = opnd_sel;
            end else begin
                s_d.src  = '0;
                s_d.dst  = '0;
                s_d.typ  = NOP_TYPE;
                s_d.grp  = G_MISC;
                s_d.byt  = 1'b0;
                s_d.lng  = 1'b0;
                s_d.opnd = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.fsm <= ST_BOOT;
            s_q.pc  <= RESET_PC;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req     = (s_q.fsm == ST_HEAD) || (s_q.fsm == ST_TAIL);
    assign mem_addr    = s_q.pc;
    assign dec_valid   = s_q.valid;
    assign dec_pc      = s_q.ipc;
    assign dec_src     = s_q.src;
    assign dec_dst     = s_q.dst;
    assign dec_group   = s_q.grp;
    assign dec_type    = s_q.typ;
    assign dec_byte    = s_q.byt;
    assign dec_long    = s_q.lng;
    assign dec_operand = s_q.opnd;
    assign dec_illegal = s_q.ill;

    assert_addr_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_idle_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !mem_req);

    assert_illegal_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_illegal) |-> (dec_group == G_MISC && dec_type == NOP_TYPE &&
                                        !dec_long && !dec_byte && dec_operand == '0));

    assert_short_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_long) |-> (dec_operand == '0));

    assert_bundle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> ($stable(dec_pc) && $stable(dec_operand) &&
                        $stable(dec_group) && $stable(dec_type) && $stable(dec_illegal)));

endmodule

// File: rtl/ifd_fetch_decode.sv
module ifd_fetch_decode
    import ifd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [15:0]       mem_rdata,
    input  logic              exec_ready,
    input  logic              redirect_valid,
    input  logic [ADDR_W-1:0] redirect_pc,
    output logic              dec_valid,
    output logic [ADDR_W-1:0] dec_pc,
    output logic [3:0]        dec_src,
    output logic [3:0]        dec_dst,
    output logic [3:0]        dec_group,
    output logic [3:0]        dec_type,
    output logic              dec_byte,
    output logic              dec_long,
    output logic [15:0]       dec_operand,
    output logic              dec_illegal
);

    logic [WORD_W-1:0] cls_word;
    cls_t              cls;

    ifd_classify u_classify (
        .word (cls_word),
        .cls  (cls)
    );

    ifd_sequencer #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_rvalid     (mem_rvalid),
        .mem_rdata      (mem_rdata),
        .exec_ready     (exec_ready),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .cls_word       (cls_word),
        .cls            (cls),
        .dec_valid      (dec_valid),
        .dec_pc         (dec_pc),
        .dec_src        (dec_src),
        .dec_dst        (dec_dst),
        .dec_group      (dec_group),
        .dec_type       (dec_type),
        .dec_byte       (dec_byte),
        .dec_long       (dec_long),
        .dec_operand    (dec_operand),
        .dec_illegal    (dec_illegal)
    );

endmodule

// File: tb/ifd_fetch_decode_tb.sv
module ifd_fetch_decode_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        exec_ready = 1'b0;
    logic        redirect_valid = 1'b0;
    logic [15:0] redirect_pc = '0;
    logic        dec_valid;
    logic [15:0] dec_pc;
    logic [3:0]  dec_src, dec_dst, dec_group, dec_type;
    logic        dec_byte, dec_long, dec_illegal;
    logic [15:0] dec_operand;

    logic [15:0] mem [256];
    int lat = 0;
    bit spurious = 1'b0;
    int wcnt = 0;
    int fetch_cnt = 0;
    int last_cnt = 0;
    int chk = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ifd_fetch_decode #(.ADDR_W(16), .RESET_PC(16'h0000)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .exec_ready(exec_ready), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_src(dec_src), .dec_dst(dec_dst),
        .dec_group(dec_group), .dec_type(dec_type), .dec_byte(dec_byte),
        .dec_long(dec_long), .dec_operand(dec_operand), .dec_illegal(dec_illegal)
    );

    // memory model: one response per request, programmable wait, stray valids when idle
    always @(negedge clk) begin
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[mem_addr[8:1]];
                fetch_cnt++;
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
            if (spurious) begin
                mem_rvalid = 1'b1;
                mem_rdata  = 16'hDEAD;
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", chk, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 20000", cyc);
            report();
        end
    end

    task automatic check(input string req, input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        chk++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic release_hold(input bit redir, input logic [15:0] rpc);
        @(negedge clk);
        exec_ready     = 1'b1;
        redirect_valid = redir;
        redirect_pc    = rpc;
        @(negedge clk);
        exec_ready     = 1'b0;
        redirect_valid = 1'b0;
        last_cnt       = fetch_cnt;
    endtask

    task automatic expect_instr(input string req, input logic [15:0] e_pc,
                                input logic [3:0] e_src, input logic [3:0] e_dst,
                                input logic [3:0] e_grp, input logic [3:0] e_typ,
                                input logic e_byte, input logic e_long, input logic e_ill,
                                input logic [15:0] e_op, input int e_words);
        logic [63:0] act, exp;
        bit seen = 1'b0;
        for (int i = 0; i < 100 && !seen; i++) begin
            @(negedge clk);
            if (dec_valid) seen = 1'b1;
        end
        check(req, seen, "decode strobe seen", 64'(seen), 64'd1);
        act = {dec_pc, dec_src, dec_dst, dec_group, dec_type, 1'b0, dec_byte, dec_long, dec_illegal, dec_operand};
        exp = {e_pc, e_src, e_dst, e_grp, e_typ, 1'b0, e_byte, e_long, e_ill, e_op};
        check(req, act == exp, "bundle {pc,src,dst,grp,typ,flags,op}", act, exp);
        check("R3", (fetch_cnt - last_cnt) == e_words, "words read", 64'(fetch_cnt - last_cnt), 64'(e_words));
        @(negedge clk);
        check("R6", !dec_valid && !mem_req, "strobe width / idle {valid,req}",
              {62'd0, dec_valid, mem_req}, 64'd0);
        @(negedge clk);
        check("R10", !mem_req && dec_operand == e_op && dec_pc == e_pc, "held {req,op,pc}",
              {31'd0, mem_req, dec_operand, dec_pc}, {32'd0, e_op, e_pc});
    endtask

    task automatic t_reset();
        mem_req_low: for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1", !mem_req && !dec_valid, "idle in reset {req,valid}",
                  {62'd0, mem_req, dec_valid}, 64'd0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 10 && !mem_req; i++) @(negedge clk);
        check("R1", mem_req && mem_addr == 16'h0000, "first request {req,addr}",
              {47'd0, mem_req, mem_addr}, {47'd0, 1'b1, 16'h0000});
    endtask

    task automatic t_basic_lengths();
        expect_instr("R2", 16'h0000, 4'd1, 4'd2, 4'd0, 4'd0, 0, 0, 0, 16'h0000, 1);
        release_hold(0, 0);
        expect_instr("R3", 16'h0002, 4'd0, 4'd1, 4'd0, 4'd2, 0, 1, 0, 16'h000F, 2);
        release_hold(0, 0);
        expect_instr("R3", 16'h0006, 4'd0, 4'd0, 4'd1, 4'd0, 0, 1, 0, 16'h1234, 2);
        release_hold(0, 0);
        expect_instr("R4", 16'h000A, 4'd3, 4'd4, 4'd5, 4'd1, 0, 1, 0, 16'hBEEF, 2);
        release_hold(0, 0);
        expect_instr("R8", 16'h000E, 4'd2, 4'd1, 4'd3, 4'd9, 1, 0, 0, 16'h0000, 1);
        release_hold(0, 0);
        expect_instr("R7", 16'h0010, 4'd0, 4'd0, 4'd0, 4'd11, 0, 0, 0, 16'h0000, 1);
        release_hold(0, 0);
        expect_instr("R7", 16'h0012, 4'd0, 4'd0, 4'd0, 4'd1, 0, 0, 1, 16'h0000, 1);
        lat = 3;
        release_hold(0, 0);
    endtask

    task automatic t_slow_memory_and_illegal();
        expect_instr("R5", 16'h0014, 4'd7, 4'd8, 4'd6, 4'd3, 0, 1, 0, 16'h1111, 2);
        release_hold(0, 0);
        expect_instr("R7", 16'h0018, 4'd0, 4'd0, 4'd0, 4'd1, 0, 0, 1, 16'h0000, 1);
        release_hold(0, 0);
        expect_instr("R7", 16'h001A, 4'd0, 4'd0, 4'd0, 4'd1, 0, 0, 1, 16'h0000, 1);
        release_hold(0, 0);
        expect_instr("R8", 16'h001C, 4'd1, 4'd2, 4'd9, 4'd6, 1, 1, 0, 16'h00AA, 2);
        release_hold(0, 0);
        expect_instr("R7", 16'h0020, 4'd0, 4'd0, 4'd0, 4'd1, 0, 0, 1, 16'h0000, 1);
        release_hold(0, 0);
        expect_instr("R8", 16'h0022, 4'd4, 4'd5, 4'd8, 4'd15, 1, 1, 0, 16'h7777, 2);
        release_hold(0, 0);
        expect_instr("R7", 16'h0026, 4'd0, 4'd0, 4'd0, 4'd1, 0, 0, 1, 16'h0000, 1);
        spurious = 1'b1;
        lat = 1;
        release_hold(0, 0);
        expect_instr("R5", 16'h0028, 4'd0, 4'd0, 4'd0, 4'd0, 0, 0, 0, 16'h0000, 1);
    endtask

    task automatic t_redirects();
        release_hold(1, 16'h0041);
        expect_instr("R9", 16'h0040, 4'd0, 4'd1, 4'd2, 4'd0, 0, 1, 0, 16'h4242, 2);
        @(negedge clk);
        redirect_valid = 1'b1;
        redirect_pc    = 16'h0080;
        @(negedge clk);
        @(negedge clk);
        redirect_valid = 1'b0;
        check("R9", !mem_req, "lone redirect starts no fetch", 64'(mem_req), 64'd0);
        release_hold(0, 0);
        expect_instr("R9", 16'h0044, 4'd0, 4'd0, 4'd0, 4'd10, 0, 0, 0, 16'h0000, 1);
        spurious = 1'b0;
        lat = 0;
        release_hold(1, 16'hFFFC);
        expect_instr("R4", 16'hFFFC, 4'd0, 4'd1, 4'd0, 4'd2, 0, 1, 0, 16'h5A5A, 2);
        release_hold(0, 0);
        expect_instr("R4", 16'h0000, 4'd1, 4'd2, 4'd0, 4'd0, 0, 0, 0, 16'h0000, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h00] = 16'h1200;
        mem[8'h01] = 16'h0120; mem[8'h02] = 16'h000F;
        mem[8'h03] = 16'h0001; mem[8'h04] = 16'h1234;
        mem[8'h05] = 16'h3415; mem[8'h06] = 16'hBEEF;
        mem[8'h07] = 16'h2193;
        mem[8'h08] = 16'h00B0;
        mem[8'h09] = 16'h560B;
        mem[8'h0A] = 16'h7836; mem[8'h0B] = 16'h1111;
        mem[8'h0C] = 16'h9A86;
        mem[8'h0D] = 16'h0079;
        mem[8'h0E] = 16'h1269; mem[8'h0F] = 16'h00AA;
        mem[8'h10] = 16'h00D1;
        mem[8'h11] = 16'h45F8; mem[8'h12] = 16'h7777;
        mem[8'h13] = 16'h0033;
        mem[8'h14] = 16'h0000;
        mem[8'h20] = 16'h0102; mem[8'h21] = 16'h4242;
        mem[8'h22] = 16'h00A0;
        mem[8'hFE] = 16'h0120; mem[8'hFF] = 16'h5A5A;
        t_reset();
        t_basic_lengths();
        t_slow_memory_and_illegal();
        t_redirects();
        report();
    end

endmodule